// File: doc/BRIEF.md
# Load/Store Instruction Sequencer

This block is a multicycle control unit with its datapath slice for a 16-bit load/store instruction set. It holds the program counter, the instruction register, a memory address register, a memory data register, eight 16-bit general registers and a three-bit sign flag. It repeatedly fetches an instruction, decodes it, forms an address and runs the one or two memory transactions that the opcode calls for.

Seven opcodes are executed: load and store relative to the program counter, load and store through a pointer cell, load and store at a base register plus a small offset, and an address-forming operation that writes the computed address into a register. Every other opcode costs only its fetch and changes no state. Memory sits outside the block behind a request/ready handshake, and any transaction may take several cycles.

Top module: `ldst_seq`

## Requirements
- R1: After reset the first transaction is a read at START_ADDR (default 16'h3000). All eight registers read as zero. The sign flag is Z. While rst_n is low, mem_req is low.
- R2: A fetch reads the word at the program counter into the instruction register and increments the program counter by one. Every later address in that instruction is formed from the incremented value.
- R3: Opcode bits [15:12] select the operation: 4'b0010 PC-relative load, 4'b0011 PC-relative store, 4'b1010 pointer load, 4'b1011 pointer store, 4'b0110 base load, 4'b0111 base store, 4'b1110 address-forming. Bits [11:9] name the data register and bits [8:6] name the base register.
- R4: A PC-relative load makes one read at PC+sext(IR[8:0]) and writes the returned word into the data register.
- R5: A pointer access first reads the cell at PC+sext(IR[8:0]). The load form then reads at the returned pointer and writes that word to the data register.
- R6: A store makes exactly one write, carrying the data register's value. For the pointer form that write goes to the address read from the pointer cell, after the cell read.
- R7: Base-relative forms access register[IR[8:6]]+sext(IR[5:0]), with the offset taken as signed.
- R8: The address-forming opcode writes PC+sext(IR[8:0]) into the data register and makes no data read or write.
- R9: The flag cc_o is one-hot, with bit 2 = negative, bit 1 = zero and bit 0 = positive. Only the three load forms update it, from the value written. Stores, address-forming and other opcodes leave it unchanged.
- R10: While mem_req is high and mem_ready is low, mem_req, mem_addr, mem_we and mem_wdata hold steady. A transaction completes on the cycle that mem_ready is high.
- R11: An opcode outside the seven makes no transaction beyond its own fetch, and the next fetch reads the following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | DATA_W | Transaction address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Completes the pending transaction this cycle |
| cc_o | output | 3 | One-hot sign flag {N,Z,P} |

## Verification
A corrupted register or a wrong incremented program counter has no port of its own. It appears at the next store that carries the register, or at the next fetch address, as a wrong mem_wdata or mem_addr within one instruction. A mis-sequenced phase shows at once as an extra, missing or misdirected transaction, or as a read where a write was due. A stale or wrongly updated sign flag is visible on cc_o at the following fetch. The bench therefore compares every completed transaction, in order, against an instruction-level model, under random memory latency.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  // Instruction field positions (16-bit encoding)
  localparam int OPC_MSB    = 15;
  localparam int OPC_LSB    = 12;
  localparam int FLD_DR_LSB = 9;
  localparam int FLD_BR_LSB = 6;
  localparam int OFF9_W     = 9;
  localparam int OFF6_W     = 6;

  localparam logic [3:0] OPC_LD  = 4'b0010;
  localparam logic [3:0] OPC_ST  = 4'b0011;
  localparam logic [3:0] OPC_LDI = 4'b1010;
  localparam logic [3:0] OPC_STI = 4'b1011;
  localparam logic [3:0] OPC_LDR = 4'b0110;
  localparam logic [3:0] OPC_STR = 4'b0111;
  localparam logic [3:0] OPC_LEA = 4'b1110;

  // Sign flag bit positions
  localparam int CC_W = 3;
  localparam int CC_N = 2;
  localparam int CC_Z = 1;
  localparam int CC_P = 0;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_PTR    = 3'd2,
    PH_READ   = 3'd3,
    PH_EXEC   = 3'd4,
    PH_WRITE  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    AM_PCREL = 2'd0,
    AM_INDIR = 2'd1,
    AM_BASE  = 2'd2,
    AM_NONE  = 2'd3
  } amode_e;

  typedef struct packed {
    logic   is_load;
    logic   is_store;
    logic   is_lea;
    amode_e mode;
  } op_class_t;

  function automatic op_class_t classify(input logic [3:0] opc);
    op_class_t c;
    c = '{is_load: 1'b0, is_store: 1'b0, is_lea: 1'b0, mode: AM_NONE};
    case (opc)
      OPC_LD:  begin c.is_load  = 1'b1; c.mode = AM_PCREL; end
      OPC_ST:  begin c.is_store = 1'b1; c.mode = AM_PCREL; end
      OPC_LDI: begin c.is_load  = 1'b1; c.mode = AM_INDIR; end
      OPC_STI: begin c.is_store = 1'b1; c.mode = AM_INDIR; end
      OPC_LDR: begin c.is_load  = 1'b1; c.mode = AM_BASE;  end
      OPC_STR: begin c.is_store = 1'b1; c.mode = AM_BASE;  end
      OPC_LEA: begin c.is_lea   = 1'b1; c.mode = AM_PCREL; end
      default: c.mode = AM_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  localparam int AW     = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [AW-1:0]     rd_a_idx,
  output logic [DATA_W-1:0] rd_a_val,
  input  logic [AW-1:0]     rd_b_idx,
  output logic [DATA_W-1:0] rd_b_val
);

  logic [DATA_W-1:0] bank [REG_CNT];

  for (genvar i = 0; i < REG_CNT; i++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    logic              ent_en;

    assign ent_en = wr_en && (wr_idx == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= wr_val;
      end
    end

    assign bank[i] = ent_q;
  end

  assign rd_a_val = bank[rd_a_idx];
  assign rd_b_val = bank[rd_b_idx];

endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
  import ldst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] instr,
  input  amode_e            mode,
  output logic [DATA_W-1:0] ea
);

  logic [DATA_W-1:0] off9_ext;
  logic [DATA_W-1:0] off6_ext;

  assign off9_ext = {{(DATA_W-OFF9_W){instr[OFF9_W-1]}}, instr[OFF9_W-1:0]};
  assign off6_ext = {{(DATA_W-OFF6_W){instr[OFF6_W-1]}}, instr[OFF6_W-1:0]};

  always_comb begin
    if (mode == AM_BASE) begin
      ea = base_val + off6_ext;
    end else begin
      ea = pc_val + off9_ext;
    end
  end

endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  op_class_t cls,
  input  logic      mem_ready,
  output phase_e    phase,
  output logic      ir_en,
  output logic      mar_from_agen,
  output logic      mar_from_mem,
  output logic      mdr_from_mem,
  output logic      mdr_from_reg,
  output logic      rf_we,
  output logic      rf_take_ea,
  output logic      cc_en
);

  phase_e phase_q;
  phase_e phase_d;

  // next phase
  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_FETCH: begin
        if (mem_ready) phase_d = PH_DECODE;
      end
      PH_DECODE: begin
        if (cls.is_lea || cls.mode == AM_NONE) begin
          phase_d = PH_FETCH;
        end else if (cls.mode == AM_INDIR) begin
          phase_d = PH_PTR;
        end else if (cls.is_store) begin
          phase_d = PH_WRITE;
        end else begin
          phase_d = PH_READ;
        end
      end
      PH_PTR: begin
        if (mem_ready) phase_d = cls.is_store ? PH_WRITE : PH_READ;
      end
      PH_READ: begin
        if (mem_ready) phase_d = PH_EXEC;
      end
      PH_EXEC: begin
        phase_d = PH_FETCH;
      end
      PH_WRITE: begin
        if (mem_ready) phase_d = PH_FETCH;
      end
      default: phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
    end else begin
      phase_q <= phase_d;
    end
  end

  // datapath strobes
  always_comb begin
    ir_en         = (phase_q == PH_FETCH) && mem_ready;
    mar_from_agen = (phase_q == PH_DECODE) && (cls.mode != AM_NONE) && !cls.is_lea;
    mar_from_mem  = (phase_q == PH_PTR) && mem_ready;
    mdr_from_mem  = mem_ready && ((phase_q == PH_READ) ||
                                  ((phase_q == PH_PTR) && cls.is_load));
    mdr_from_reg  = ((phase_q == PH_DECODE) && cls.is_store && (cls.mode != AM_INDIR)) ||
                    ((phase_q == PH_PTR) && mem_ready && cls.is_store);
    rf_take_ea    = (phase_q == PH_DECODE) && cls.is_lea;
    rf_we         = (phase_q == PH_EXEC) || rf_take_ea;
    cc_en         = (phase_q == PH_EXEC);
  end

  assign phase = phase_q;

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
#(
  parameter int                 DATA_W     = 16,
  parameter int                 REG_CNT    = 8,
  parameter logic [DATA_W-1:0]  START_ADDR = 16'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [CC_W-1:0]   cc_o
);

  localparam int REG_AW = $clog2(REG_CNT);
  localparam int SYNC_N = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_q_n = rst_pipe[SYNC_N-1];

  // architectural state
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q;
  logic [CC_W-1:0]   cc_q;

  phase_e    phase;
  op_class_t cls;
  logic      ir_en;
  logic      mar_from_agen;
  logic      mar_from_mem;
  logic      mdr_from_mem;
  logic      mdr_from_reg;
  logic      rf_we;
  logic      rf_take_ea;
  logic      cc_en;

  logic [DATA_W-1:0] ea;
  logic [DATA_W-1:0] src_val;
  logic [DATA_W-1:0] base_val;
  logic [DATA_W-1:0] rf_wval;
  logic [DATA_W-1:0] mar_d;
  logic [DATA_W-1:0] mdr_d;
  logic              mar_en;
  logic              mdr_en;
  logic [CC_W-1:0]   cc_d;
  logic [REG_AW-1:0] dr_idx;
  logic [REG_AW-1:0] br_idx;

  assign cls    = classify(ir_q[OPC_MSB:OPC_LSB]);
  assign dr_idx = ir_q[FLD_DR_LSB +: REG_AW];
  assign br_idx = ir_q[FLD_BR_LSB +: REG_AW];

  ldst_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .cls           (cls),
    .mem_ready     (mem_ready),
    .phase         (phase),
    .ir_en         (ir_en),
    .mar_from_agen (mar_from_agen),
    .mar_from_mem  (mar_from_mem),
    .mdr_from_mem  (mdr_from_mem),
    .mdr_from_reg  (mdr_from_reg),
    .rf_we         (rf_we),
    .rf_take_ea    (rf_take_ea),
    .cc_en         (cc_en)
  );

  ldst_agen #(.DATA_W(DATA_W)) u_agen (
    .pc_val   (pc_q),
    .base_val (base_val),
    .instr    (ir_q),
    .mode     (cls.mode),
    .ea       (ea)
  );

  assign rf_wval = rf_take_ea ? ea : mdr_q;

  ldst_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (rf_we),
    .wr_idx   (dr_idx),
    .wr_val   (rf_wval),
    .rd_a_idx (dr_idx),
    .rd_a_val (src_val),
    .rd_b_idx (br_idx),
    .rd_b_val (base_val)
  );

  // program counter and instruction register
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_q <= START_ADDR;
    end else if (ir_en) begin
      pc_q <= pc_q + DATA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ir_q <= '0;
    end else if (ir_en) begin
      ir_q <= mem_rdata;
    end
  end

  // address and data registers
  always_comb begin
    mar_en = mar_from_agen || mar_from_mem;
    mar_d  = mar_from_mem ? mem_rdata : ea;
    mdr_en = mdr_from_mem || mdr_from_reg;
    mdr_d  = mdr_from_mem ? mem_rdata : src_val;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mar_q <= '0;
    end else if (mar_en) begin
      mar_q <= mar_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mdr_q <= '0;
    end else if (mdr_en) begin
      mdr_q <= mdr_d;
    end
  end

  // sign flag, taken from the word being written back by a load
  always_comb begin
    cc_d       = '0;
    cc_d[CC_N] = mdr_q[DATA_W-1];
    cc_d[CC_Z] = (mdr_q == '0);
    cc_d[CC_P] = !mdr_q[DATA_W-1] && (mdr_q != '0);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cc_q <= CC_W'(1 << CC_Z);
    end else if (cc_en) begin
      cc_q <= cc_d;
    end
  end

  // memory port
  always_comb begin
    mem_req   = rst_q_n && ((phase == PH_FETCH) || (phase == PH_PTR) ||
                            (phase == PH_READ)  || (phase == PH_WRITE));
    mem_we    = rst_q_n && (phase == PH_WRITE);
    mem_addr  = (phase == PH_FETCH) ? pc_q : mar_q;
    mem_wdata = mdr_q;
  end

  assign cc_o = cc_q;

endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk
  import ldst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic [CC_W-1:0]   cc_o,
  input phase_e            phase,
  input logic [DATA_W-1:0] pc_q,
  input logic [DATA_W-1:0] ir_q
);

  op_class_t chk_cls;
  assign chk_cls = classify(ir_q[OPC_MSB:OPC_LSB]);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

  p_write_in_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  p_cc_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_o) == 1);

  p_cc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_EXEC) |=> $stable(cc_o));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH && mem_req && mem_ready) |=> (pc_q == $past(pc_q) + DATA_W'(1)));

  p_lea_nomem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DECODE && chk_cls.is_lea) |=> (phase == PH_FETCH));

  p_other_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DECODE && chk_cls.mode == AM_NONE) |=> (phase == PH_FETCH));

  p_ptr_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DECODE && chk_cls.mode == AM_INDIR) |=> (phase == PH_PTR && !mem_we));

endmodule

bind ldst_seq ldst_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .cc_o      (cc_o),
  .phase     (phase),
  .pc_q      (pc_q),
  .ir_q      (ir_q)
);

// File: tb/ldst_seq_tb_top.sv
module ldst_seq_tb_top;

  localparam logic [15:0] START  = 16'h3000;
  localparam int          N_INSTR = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ready;
  logic [2:0]  cc_o;

  always #2 clk = ~clk;

  ldst_seq #(.DATA_W(16), .REG_CNT(8), .START_ADDR(START)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .cc_o      (cc_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [15:0] mem_m [int unsigned];
  logic [15:0] rmem  [int unsigned];

  typedef enum int {K_FETCH, K_FETCH_LEA, K_FETCH_NOP, K_LD, K_IND, K_ST, K_BASE} kind_e;
  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic [15:0] wdata;
    kind_e       kind;
    logic [2:0]  cc;
  } xact_t;

  xact_t       exp_q[$];
  logic [15:0] rregs [8];
  logic [15:0] rpc;
  logic [2:0]  rcc;
  int          n_instr = 0;
  kind_e       next_fetch_kind = K_FETCH;

  function automatic logic [15:0] rd_m(input logic [15:0] a);
    return mem_m.exists(a) ? mem_m[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] rd_r(input logic [15:0] a);
    return rmem.exists(a) ? rmem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] sx9(input logic [8:0] v);
    return {{7{v[8]}}, v};
  endfunction

  function automatic logic [15:0] sx6(input logic [5:0] v);
    return {{10{v[5]}}, v};
  endfunction

  function automatic logic [2:0] cc_of(input logic [15:0] v);
    if (v[15])          return 3'b100;
    else if (v == 16'h0) return 3'b010;
    else                return 3'b001;
  endfunction

  function automatic string tag_of(input kind_e k);
    case (k)
      K_FETCH:     return "R2";
      K_FETCH_LEA: return "R8";
      K_FETCH_NOP: return "R11";
      K_LD:        return "R4";
      K_IND:       return "R5";
      K_ST:        return "R6";
      default:     return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic we, input logic [15:0] wd,
                      input kind_e k, input logic [2:0] c);
    xact_t x;
    x.addr = a; x.we = we; x.wdata = wd; x.kind = k; x.cc = c;
    exp_q.push_back(x);
  endtask

  // instruction-level model: queues the transactions one instruction should make
  task automatic ref_step();
    logic [15:0] ins, a9, a6, v, p;
    logic [2:0]  r;
    ins = rd_r(rpc);
    push(rpc, 1'b0, 16'h0, next_fetch_kind, rcc);
    next_fetch_kind = K_FETCH;
    rpc = rpc + 16'h1;                         // R2: later addresses use PC+1
    r  = ins[11:9];
    a9 = rpc + sx9(ins[8:0]);
    a6 = rregs[ins[8:6]] + sx6(ins[5:0]);      // R7
    case (ins[15:12])                          // R3 opcode decode
      4'b0010: begin
        v = rd_r(a9); push(a9, 1'b0, 16'h0, K_LD, 3'b000);
        rregs[r] = v; rcc = cc_of(v);
      end
      4'b0011: begin
        push(a9, 1'b1, rregs[r], K_ST, 3'b000); rmem[a9] = rregs[r];
      end
      4'b1010: begin
        p = rd_r(a9); push(a9, 1'b0, 16'h0, K_IND, 3'b000);
        v = rd_r(p);  push(p, 1'b0, 16'h0, K_IND, 3'b000);
        rregs[r] = v; rcc = cc_of(v);
      end
      4'b1011: begin
        p = rd_r(a9); push(a9, 1'b0, 16'h0, K_IND, 3'b000);
        push(p, 1'b1, rregs[r], K_ST, 3'b000); rmem[p] = rregs[r];
      end
      4'b0110: begin
        v = rd_r(a6); push(a6, 1'b0, 16'h0, K_BASE, 3'b000);
        rregs[r] = v; rcc = cc_of(v);
      end
      4'b0111: begin
        push(a6, 1'b1, rregs[r], K_BASE, 3'b000); rmem[a6] = rregs[r];
      end
      4'b1110: begin
        rregs[r] = a9; next_fetch_kind = K_FETCH_LEA;
      end
      default: next_fetch_kind = K_FETCH_NOP;
    endcase
    n_instr++;
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] r,
                                      input logic [8:0] low);
    return {op, r, low};
  endfunction

  function automatic logic [8:0] rel(input logic [15:0] at, input logic [15:0] tgt);
    logic [15:0] d;
    d = tgt - (at + 16'h1);
    return d[8:0];
  endfunction

  task automatic poke(input logic [15:0] a, input logic [15:0] v);
    mem_m[a] = v;
    rmem[a]  = v;
  endtask

  task automatic build_program();
    logic [15:0] a;
    logic [15:0] t;
    logic [2:0]  r, b;
    logic [3:0]  other [9];
    other = '{4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9, 4'hC, 4'hD, 4'hF};
    // data and pointer cells
    for (int i = 16'h3082; i < 16'h30C0; i++) begin
      if ($urandom % 2 == 0) poke(16'(i), 16'h8000 + 16'($urandom % 32));
      else                   poke(16'(i), 16'h30C0 + 16'($urandom % 64));
    end
    for (int i = 16'h30C3; i < 16'h3100; i++) begin
      if ($urandom % 4 == 0) poke(16'(i), 16'h0000);
      else                   poke(16'(i), 16'($urandom));
    end
    for (int i = 0; i < 32; i++) poke(16'h8000 + 16'(i), 16'($urandom));
    poke(16'h3080, 16'h30C2);
    poke(16'h3081, 16'h8000);
    poke(16'h30C0, 16'h8000);
    poke(16'h30C1, 16'h0000);
    poke(16'h30C2, 16'h0005);
    // directed prefix
    poke(16'h3000, enc(4'hE, 3'd0, 9'h000));                            // R8: R0 = x3001
    poke(16'h3001, enc(4'h3, 3'd7, rel(16'h3001, 16'h30C3)));           // R1: R7 is zero
    poke(16'h3002, enc(4'h3, 3'd0, rel(16'h3002, 16'h30C4)));           // R8 value out
    poke(16'h3003, enc(4'h2, 3'd1, rel(16'h3003, 16'h30C0)));           // R4/R9 negative
    poke(16'h3004, enc(4'h3, 3'd1, rel(16'h3004, 16'h30C5)));           // R9 store keeps N
    poke(16'h3005, enc(4'hA, 3'd2, rel(16'h3005, 16'h3080)));           // R5 positive
    poke(16'h3006, enc(4'h6, 3'd3, {3'd0, 6'h3F}));                     // R7 offset -1
    poke(16'h3007, enc(4'h2, 3'd4, rel(16'h3007, 16'h30C1)));           // R9 zero
    poke(16'h3008, enc(4'h1, 3'd7, 9'h1FF));                            // R11
    poke(16'h3009, enc(4'hB, 3'd2, rel(16'h3009, 16'h3081)));           // R6 pointer store
    poke(16'h300A, enc(4'hA, 3'd5, rel(16'h300A, 16'h3081)));           // R5 readback
    poke(16'h300B, enc(4'h7, 3'd3, {3'd6, 6'h1F}));                     // R7 base zero
    // random body
    for (int i = 16'h300C; i < 16'h3080; i++) begin
      a = 16'(i);
      r = 3'($urandom % 8);
      case ($urandom % 8)
        0: begin t = 16'h3080 + 16'($urandom % 128); poke(a, enc(4'h2, 3'($urandom % 6), rel(a, t))); end
        1: begin t = 16'h30C0 + 16'($urandom % 64);  poke(a, enc(4'h3, r, rel(a, t))); end
        2: begin t = 16'h3080 + 16'($urandom % 64);  poke(a, enc(4'hA, 3'($urandom % 6), rel(a, t))); end
        3: begin t = 16'h3080 + 16'($urandom % 64);  poke(a, enc(4'hB, r, rel(a, t))); end
        4: begin b = 3'($urandom % 8); poke(a, enc(4'h6, 3'($urandom % 6), {b, 6'($urandom)})); end
        5: begin b = 3'd6 + 3'($urandom % 2); poke(a, enc(4'h7, r, {b, 6'($urandom % 32)})); end
        6: begin
          if (r >= 3'd6) begin
            t = 16'h30C0 + 16'($urandom % 32);
            poke(a, enc(4'hE, r, rel(a, t)));
          end else begin
            poke(a, enc(4'hE, r, 9'($urandom)));
          end
        end
        default: poke(a, {other[$urandom % 9], 12'($urandom)});
      endcase
    end
  endtask

  // memory responder with random latency
  initial begin
    int          wait_cnt;
    bit          prev_wait;
    logic [15:0] prev_addr;
    logic        prev_we;
    logic [15:0] prev_wdata;
    xact_t       e;
    wait_cnt  = 0;
    prev_wait = 1'b0;
    prev_addr = '0;
    prev_we   = 1'b0;
    prev_wdata = '0;
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n || done) begin
        mem_ready = 1'b0;
        prev_wait = 1'b0;
      end else begin
        if (prev_wait) begin
          // R10: request held steady while waiting
          check(mem_req && mem_addr == prev_addr && mem_we == prev_we &&
                (!prev_we || mem_wdata == prev_wdata), "R10", "held request",
                {15'h0, mem_req, mem_addr}, {15'h1, 1'b1, prev_addr});
        end
        if (!mem_req) begin
          mem_ready = 1'b0;
          prev_wait = 1'b0;
        end else if (wait_cnt != 0) begin
          mem_ready  = 1'b0;
          wait_cnt   = wait_cnt - 1;
          prev_wait  = 1'b1;
          prev_addr  = mem_addr;
          prev_we    = mem_we;
          prev_wdata = mem_wdata;
        end else begin
          if (exp_q.size() == 0 && n_instr < N_INSTR) ref_step();
          if (exp_q.size() == 0) begin
            done      = 1'b1;
            mem_ready = 1'b0;
          end else begin
            e = exp_q.pop_front();
            check(mem_addr == e.addr && mem_we == e.we, tag_of(e.kind), "address/direction",
                  {15'h0, mem_we, mem_addr}, {15'h0, e.we, e.addr});
            if (e.we) begin
              check(mem_wdata == e.wdata, tag_of(e.kind), "write data",
                    {16'h0, mem_wdata}, {16'h0, e.wdata});
            end
            if (e.kind == K_FETCH || e.kind == K_FETCH_LEA || e.kind == K_FETCH_NOP) begin
              check(cc_o == e.cc, "R9", "sign flag", {29'h0, cc_o}, {29'h0, e.cc});
            end
            if (mem_we) mem_m[mem_addr] = mem_wdata;
            else        mem_rdata = rd_m(mem_addr);
            mem_ready = 1'b1;
            wait_cnt  = int'($urandom % 4);
            prev_wait = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    int cyc;
    void'($urandom(32'h0000_5EED));
    rst_n = 1'b0;
    for (int i = 0; i < 8; i++) rregs[i] = 16'h0;
    rpc = START;
    rcc = 3'b010;
    build_program();
    repeat (4) @(negedge clk);
    check(cc_o == 3'b010, "R1", "flag in reset", {29'h0, cc_o}, 32'h2);
    check(!mem_req && !mem_we, "R1", "no request in reset", {30'h0, mem_req, mem_we}, 32'h0);
    rst_n = 1'b1;
    cyc = 0;
    while (!mem_req && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    check(mem_req && !mem_we && mem_addr == START, "R1", "first fetch",
          {15'h0, mem_req, mem_addr}, {15'h0, 1'b1, START});
    check(cc_o == 3'b010, "R1", "flag after release", {29'h0, cc_o}, 32'h2);
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d instructions expected %0d", n_instr, N_INSTR);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule